// File: doc/BRIEF.md
# Prescaled Compare-Match Event Timer

This block is a single-channel tick timer. A 16-bit up-counter advances once for every 2^scale pulses of a slow reference strobe (nominally 32.768 kHz, presented as a one-cycle enable `tick_32k` in the system clock domain). Two 16-bit compare registers set sticky event flags when the counter reaches them. The second compare also ends the count period. On the next prescaled step after a second-compare match, the counter goes back to zero, so a running timer produces events every `cmp_b + 1` steps. Software reloads the counter and re-arms the timer for one-shot use.

Software reaches four 16-bit registers through a plain write strobe, a 2-bit select and a combinational read port. The control/status register holds the following fields:
- bit 15: count enable.
- bit 14: second-compare flag.
- bit 13: first-compare flag.
- bit 12: configured status.
- bits [9:8]: event mode.
- bits [3:0]: prescale exponent.

The prescale exponent and the event mode can be written only once. The first write to the control register latches them and sets the configured bit. Later writes change only the enable bit and clear flags. A single write can therefore stop the timer and clear both flags without disturbing the configuration. The interrupt output is a level signal. It is high while the second-compare flag is set and the event mode is 3.

Top module: `cmp_event_timer`

## Requirements
- R1: After reset, the control register, the counter and both compare registers read 0, and `irq` is 0.
- R2: The first write to the control register (select 0) loads the exponent (bits [3:0]) and the mode (bits [9:8]), and sets the configured bit 12. Later writes to the control register leave the exponent, the mode and bit 12 unchanged.
- R3: While bit 15 is 1, the counter increments once per 2^e `tick_32k` pulses. Here e is the exponent, and any exponent above 8 acts as 8. The stored exponent still reads back unchanged.
- R4: While bit 15 is 0, `tick_32k` pulses change neither the counter nor the progress of the prescaler.
- R5: A write to select 1 loads the counter with `wr_data` and restarts the prescaler from zero, so a full 2^e pulses pass before the next increment.
- R6: When a step brings the counter to the value in select 3, bit 14 is set. The step after that returns the counter to 0 instead of incrementing it.
- R7: When a step brings the counter to the value in select 2, bit 13 is set. This does not alter the count sequence.
- R8: Writing the control register with bit 14 or bit 13 at 1 clears that flag, and a 0 leaves it unchanged. If a match sets a flag in the same cycle as a write clears it, the flag ends up set.
- R9: `irq` is 1 exactly while bit 14 is 1 and the mode field is 3. It is 0 for every other mode.
- R10: `rd_data` shows the register chosen by `reg_sel` (0 control, 1 counter, 2 first compare, 3 second compare) in the same cycle. Unused control bits read 0.
- R11: Compare targets use all 16 bits, including values up to 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle strobe of the slow reference |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
The counter is driven with three input patterns:
- Runs of strobes that are exact multiples of the divisor show that the divisor is correct.
- Runs that stop one strobe short show that a counter write restarts the prescaler, and that an exponent above 8 acts as 256.
- Strobes sent while the enable is off show that a frozen timer ignores them.

A periodic run across the second compare shows the flag, the interrupt and the wrap to zero. A run from 0xFFF0 to 0xFFFE exercises a wide target. A flag clear written in the same cycle as a match separates set-wins from clear-wins. A reset followed by a configuration with mode 0 shows that the interrupt stays low while the flag is set.

// File: rtl/cmp_event_timer.sv
module cmp_event_timer #(
  parameter int MAX_SCALE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_32k,
  input  logic        wr_en,
  input  logic [1:0]  reg_sel,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        irq
);
  localparam int PW = MAX_SCALE;
  localparam logic [1:0] SEL_CTRL = 2'd0, SEL_CNT = 2'd1, SEL_CMPA = 2'd2, SEL_CMPB = 2'd3;
  localparam logic [3:0] SCALE_CAP = 4'(MAX_SCALE);

  logic          run_q, flag_a_q, flag_b_q, cfg_q;
  logic [3:0]    scale_q;
  logic [1:0]    mode_q;
  logic [15:0]   cnt_q, cmp_a_q, cmp_b_q;
  logic [PW-1:0] pre_q;

  wire wr_ctrl = wr_en && reg_sel == SEL_CTRL;
  wire wr_cnt  = wr_en && reg_sel == SEL_CNT;

  wire [3:0]    eff_scale = (scale_q > SCALE_CAP) ? SCALE_CAP : scale_q;
  wire [PW:0]   div_full  = {{PW{1'b0}}, 1'b1} << eff_scale;
  wire [PW-1:0] pre_lim   = div_full[PW-1:0] - {{(PW-1){1'b0}}, 1'b1};

  wire        adv      = run_q && tick_32k && !wr_cnt;
  wire        step     = adv && pre_q == pre_lim;
  wire [15:0] cnt_next = (cnt_q == cmp_b_q) ? 16'd0 : cnt_q + 16'd1;
  wire        hit_a    = step && cnt_next == cmp_a_q;
  wire        hit_b    = step && cnt_next == cmp_b_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (wr_cnt) pre_q <= '0;
    else if (adv)    pre_q <= step ? '0 : pre_q + {{(PW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_data;
    else if (step)   cnt_q <= cnt_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else if (wr_en) begin
      if (reg_sel == SEL_CMPA) cmp_a_q <= wr_data;
      if (reg_sel == SEL_CMPB) cmp_b_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cfg_q   <= 1'b0;
      scale_q <= '0;
      mode_q  <= '0;
    end else if (wr_ctrl) begin
      run_q <= wr_data[15];
      if (!cfg_q) begin
        cfg_q   <= 1'b1;
        scale_q <= wr_data[3:0];
        mode_q  <= wr_data[9:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_a_q <= 1'b0;
      flag_b_q <= 1'b0;
    end else begin
      flag_a_q <= hit_a || (flag_a_q && !(wr_ctrl && wr_data[13]));
      flag_b_q <= hit_b || (flag_b_q && !(wr_ctrl && wr_data[14]));
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: rd_data = {run_q, flag_b_q, flag_a_q, cfg_q, 2'b00, mode_q, 4'b0000, scale_q};
      SEL_CNT:  rd_data = cnt_q;
      SEL_CMPA: rd_data = cmp_a_q;
      default:  rd_data = cmp_b_q;
    endcase
  end

  assign irq = flag_b_q && mode_q == 2'b11;
endmodule

module cmp_event_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  reg_sel,
  input logic [15:0] wr_data,
  input logic        run,
  input logic        flag_b,
  input logic        cfg,
  input logic [3:0]  scale,
  input logic [1:0]  mode,
  input logic [15:0] cnt,
  input logic        irq
);
  wire cnt_wr  = wr_en && reg_sel == 2'd1;
  wire ctrl_wr = wr_en && reg_sel == 2'd0;

  assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg |=> ($stable(scale) && $stable(mode) && cfg));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1 || cnt == 16'd0));

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wr_data));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_b && !(ctrl_wr && wr_data[14])) |=> flag_b);

  assert_irq_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg |-> !irq);
endmodule

bind cmp_event_timer cmp_event_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
  .run(run_q), .flag_b(flag_b_q), .cfg(cfg_q), .scale(scale_q), .mode(mode_q),
  .cnt(cnt_q), .irq(irq)
);

// File: tb/cmp_event_timer_test.sv
`timescale 1ns/100ps
module cmp_event_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_32k = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  cmp_event_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .wr_en(wr_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  mon_ev;
  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;

  always begin
    item_t it;
    logic [15:0] act;
    @(mon_ev);
    #1;
    it = q.pop_front();
    act = it.is_irq ? {15'd0, irq} : rd_data;
    compared++;
    if (act !== it.exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, it.exp);
    end
  end

  task automatic expect_reg(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    reg_sel = sel;
    it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
    q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {15'd0, exp}; it.tag = tag;
    q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    @(negedge clk);
    tick_32k = 1'b1;
    repeat (n) @(negedge clk);
    tick_32k = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    do_reset();
    expect_reg(2'd0, 16'h0000, "R1 ctrl");
    expect_reg(2'd1, 16'h0000, "R1 cnt");
    expect_reg(2'd2, 16'h0000, "R1 cmpa");
    expect_reg(2'd3, 16'h0000, "R1 cmpb");
    expect_irq(1'b0, "R1 irq");

    wr(2'd3, 16'h0010);
    wr(2'd2, 16'h0005);
    expect_reg(2'd3, 16'h0010, "R10 cmpb readback");
    expect_reg(2'd2, 16'h0005, "R10 cmpa readback");
    wr(2'd0, 16'h8302);
    expect_reg(2'd0, 16'h9302, "R2 first config");

    pulses(12);
    expect_reg(2'd1, 16'h0003, "R3 divide by 4");

    wr(2'd0, 16'h0000);
    pulses(20);
    expect_reg(2'd1, 16'h0003, "R4 frozen");
    wr(2'd0, 16'h0005);
    expect_reg(2'd0, 16'h1302, "R2 locked fields");

    wr(2'd0, 16'h8000);
    pulses(2);
    wr(2'd1, 16'h0000);
    pulses(3);
    expect_reg(2'd1, 16'h0000, "R5 prescaler restarted");
    pulses(1);
    expect_reg(2'd1, 16'h0001, "R5 first step");

    pulses(16);
    expect_reg(2'd1, 16'h0005, "R7 count at cmpa");
    expect_reg(2'd0, 16'hB302, "R7 flag a set");
    expect_irq(1'b0, "R9 irq low without flag b");

    pulses(44);
    expect_reg(2'd1, 16'h0010, "R6 count at cmpb");
    expect_reg(2'd0, 16'hF302, "R6 flag b set");
    expect_irq(1'b1, "R9 irq with mode 3");
    pulses(4);
    expect_reg(2'd1, 16'h0000, "R6 wrap to zero");
    pulses(4);
    expect_reg(2'd1, 16'h0001, "R6 periodic restart");

    wr(2'd0, 16'hC000);
    expect_reg(2'd0, 16'hB302, "R8 clear b only");
    expect_irq(1'b0, "R9 irq drops with flag");
    wr(2'd0, 16'hA000);
    expect_reg(2'd0, 16'h9302, "R8 clear a");

    wr(2'd1, 16'h000F);
    pulses(3);
    @(negedge clk);
    tick_32k = 1'b1; wr_en = 1'b1; reg_sel = 2'd0; wr_data = 16'hC000;
    @(negedge clk);
    tick_32k = 1'b0; wr_en = 1'b0;
    expect_reg(2'd0, 16'hD302, "R8 set wins over clear");
    expect_irq(1'b1, "R8 irq kept");
    wr(2'd0, 16'h6000);
    expect_reg(2'd0, 16'h1302, "R8 stop and clear both");
    expect_irq(1'b0, "R8 irq cleared");

    wr(2'd3, 16'hFFFE);
    wr(2'd2, 16'h000F);
    wr(2'd1, 16'hFFF0);
    wr(2'd0, 16'h8000);
    pulses(56);
    expect_reg(2'd1, 16'hFFFE, "R11 wide target reached");
    expect_reg(2'd0, 16'hD302, "R11 flag b at 0xFFFE");
    pulses(4);
    expect_reg(2'd1, 16'h0000, "R11 wrap from 0xFFFE");

    do_reset();
    expect_reg(2'd0, 16'h0000, "R1 second reset");
    wr(2'd3, 16'h0002);
    wr(2'd0, 16'h800F);
    expect_reg(2'd0, 16'h900F, "R3 raw exponent readback");
    pulses(255);
    expect_reg(2'd1, 16'h0000, "R3 clamp not yet");
    pulses(1);
    expect_reg(2'd1, 16'h0001, "R3 clamp 256");
    pulses(256);
    expect_reg(2'd0, 16'hD00F, "R6 flag b mode 0");
    expect_irq(1'b0, "R9 no irq in mode 0");

    #20;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule